// File: doc/BRIEF.md
# Byte-Wide Control Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C). A host uses it to read and write a small file of byte-wide control registers. It runs on a system clock that is at least 16 times faster than SCL. SCL and SDA first pass through a synchronizer. START, STOP and both SCL edges are then found as single-cycle events. The block drives SDA only through an open-drain enable: when the enable is high, the pad pulls the line low.

A write transfer carries the target address, then a pointer byte, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then moves on by one. A read transfer first sets the pointer with a short write. It then sends a repeated START with the read address, and the target returns bytes from the pointer, which again moves on by one after each byte. The register map is sparse. The pointer steps through the gaps, where writes are dropped and reads return zero. A status byte from the surrounding logic can be read but not written. All stored registers appear as parallel outputs that drive the dimming channels.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the outputs are: brightness 0x3F, all channel offsets 0x00, master enable 0, channel enable 0x00, SDA enable 0.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. Data bits are taken on SCL rising, most significant bit first. A STOP in the middle of a byte drops that byte.
- R3: The target answers to 7-bit address 0x6F (0xDE writes, 0xDF reads). It drives SDA low during the ninth clock of that address byte.
- R4: If the address does not match, the target sends no ACK and ignores all bytes until the next START. The registers do not change.
- R5: The first byte after a write address loads the pointer. Each later byte is written to the pointer, and the pointer then increments, so a burst fills consecutive addresses.
- R6: In a write transfer, the target ACKs every byte it receives, pointer and data alike.
- R7: After a repeated START with the read address, the target shifts out the byte at the pointer, MSB first, and increments the pointer after each byte.
- R8: The target releases SDA in the ninth clock of every byte it sends. A NACK (SDA high in that clock) ends the read, and the target drives nothing more until the next START.
- R9: Address 0x2C returns the `status_i` byte. Writes to it have no effect.
- R10: Address 0x00 is brightness, 0x01 to 0x08 are the offsets of channels 1 to 8, 0x2A is master enable (bit 0), and 0x2B is channel enable. Any other address ignores writes and reads as 0x00. The pointer passes through these unmapped addresses.
- R11: Master enable stores only bit 0. It reads back with bits 7 to 1 at zero.
- R12: The SDA enable changes only while SCL is low, except when it is released at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the pad (asynchronous) |
| sda_oe_o | output | 1 | Pull SDA low when high |
| status_i | input | 8 | Read-only status byte |
| bright_o | output | 8 | Master brightness |
| offset_o | output | 64 | Channel offsets, channel k in bits [8k-1:8k-8] |
| master_en_o | output | 1 | Master enable |
| chan_en_o | output | 8 | Per-channel enable |

## Verification
The data values are asymmetric (0xC1, 0x12, 0xA5), so a byte stored LSB first or at the wrong address is caught. A burst write followed by a burst read through a repeated START checks both pointer paths against the same stored data. Bursts that start at 0x08 and at 0x2A cross the unmapped gaps and the read-only status byte, which separates "dropped" from "stored" at the boundaries of the map. A transfer to a wrong address, a STOP in the middle of a byte, and a NACK after a read each end in a different way, and each is followed by reading the registers back.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRX, ST_WACK, ST_RTX, ST_RACK
  } i2c_state_e;

  localparam logic [7:0] A_BRIGHT = 8'h00;
  localparam logic [7:0] A_OFS0   = 8'h01;
  localparam logic [7:0] A_MEN    = 8'h2A;
  localparam logic [7:0] A_CHEN   = 8'h2B;
  localparam logic [7:0] A_STAT   = 8'h2C;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edge while SCL held high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

  AST_START_STOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o)); // R2
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_addr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  localparam int BITS = 8;
  localparam logic [3:0] LAST = 4'(BITS);

  i2c_state_e state_q;
  logic [3:0] bitcnt_q;
  logic [7:0] shift_q, tx_q, ptr_q, wr_addr_q, wr_data_q;
  logic       ptr_ok_q, rw_q, oe_q, nack_q, wr_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      ptr_ok_q  <= 1'b0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      nack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        oe_q     <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WRX: begin
            if (scl_rise_i && bitcnt_q != LAST) begin
              shift_q  <= {shift_q[6:0], sda_i};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall_i && bitcnt_q == LAST) begin
              bitcnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shift_q[7:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  rw_q    <= shift_q[0];
                  state_q <= ST_ADDR_ACK;
                  if (!shift_q[0]) ptr_ok_q <= 1'b0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                oe_q    <= 1'b1;
                state_q <= ST_WACK;
                if (!ptr_ok_q) begin
                  ptr_q    <= shift_q;
                  ptr_ok_q <= 1'b1;
                end else begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q;
                  wr_data_q <= shift_q;
                  ptr_q     <= ptr_q + 8'd1;
                end
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            bitcnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[7];
              state_q <= ST_RTX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WRX;
            end
          end
          ST_WACK: if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_WRX;
          end
          ST_RTX: begin
            if (scl_rise_i && bitcnt_q != LAST) begin
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall_i && bitcnt_q == LAST) begin
              oe_q     <= 1'b0;
              ptr_q    <= ptr_q + 8'd1;
              bitcnt_q <= '0;
              state_q  <= ST_RACK;
            end else if (scl_fall_i) begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                state_q <= ST_RTX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe_q) && !$past(start_i || stop_i)) |-> !scl_i); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q); // R4
  AST_WRITE_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (state_q == ST_WACK && oe_q)); // R6
  AST_RACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK) |-> !oe_q); // R8
endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
  import i2c_reg_pkg::*;
#(
  parameter int         NUM_OFS    = 8,
  parameter logic [7:0] BRIGHT_RST = 8'h3F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [7:0]           wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [7:0]           rd_addr_i,
  output logic [7:0]           rd_data_o,
  input  logic [7:0]           status_i,
  output logic [7:0]           bright_o,
  output logic [NUM_OFS*8-1:0] offset_o,
  output logic                 master_en_o,
  output logic [NUM_OFS-1:0]   chan_en_o
);
  logic [7:0]         bright_q;
  logic [7:0]         ofs_q [NUM_OFS];
  logic               men_q;
  logic [NUM_OFS-1:0] chen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bright_q <= BRIGHT_RST;
      men_q    <= 1'b0;
      chen_q   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_BRIGHT) bright_q <= wr_data_i;
      if (wr_addr_i == A_MEN)    men_q    <= wr_data_i[0];
      if (wr_addr_i == A_CHEN)   chen_q   <= wr_data_i[NUM_OFS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ofs_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == 8'(A_OFS0 + g)) ofs_q[g] <= wr_data_i;
    end
    assign offset_o[g*8 +: 8] = ofs_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_BRIGHT) rd_data_o = bright_q;
    if (rd_addr_i == A_MEN)    rd_data_o = {7'd0, men_q};
    if (rd_addr_i == A_CHEN)   rd_data_o = 8'(chen_q);
    if (rd_addr_i == A_STAT)   rd_data_o = status_i;
    for (int k = 0; k < NUM_OFS; k++)
      if (rd_addr_i == 8'(A_OFS0 + k)) rd_data_o = ofs_q[k];
  end

  assign bright_o    = bright_q;
  assign master_en_o = men_q;
  assign chan_en_o   = chen_q;

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(bright_q) && $stable(chen_q) && $stable(men_q))); // R5
  AST_STATUS_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_STAT) |=> ($stable(bright_q) && $stable(chen_q))); // R9
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         NUM_OFS     = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h6F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [7:0]           status_i,
  output logic [7:0]           bright_o,
  output logic [NUM_OFS*8-1:0] offset_o,
  output logic                 master_en_o,
  output logic [NUM_OFS-1:0]   chan_en_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic wr_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o
  );

  i2c_ctrl_regs #(.NUM_OFS(NUM_OFS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .status_i, .bright_o, .offset_o, .master_en_o, .chan_en_o
  );
endmodule

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe;
  logic [7:0] status = 8'h5A;
  logic [7:0] bright;
  logic [63:0] offset;
  logic men;
  logic [7:0] chen;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .status_i(status), .bright_o(bright),
    .offset_o(offset), .master_en_o(men), .chan_en_o(chen)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(Q); scl_m = 1'b1; hold(2*Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    ack = ~sda_line;
    hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl_m = 1'b1; hold(Q);
      b[i] = sda_line;
      hold(Q); scl_m = 1'b0;
    end
    hold(Q); sda_m = nack; hold(Q); scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p, input string tag);
    bit a;
    bus_start();
    send_byte(8'hDE, a); check(a, {tag, " R3 addr ack"}, a, 1);
    send_byte(p, a);     check(a, {tag, " R6 ptr ack"}, a, 1);
  endtask

  task automatic read_at(input logic [7:0] p, input int n, output logic [7:0] d [4]);
    bit a;
    set_ptr(p, "rd");
    bus_start();
    send_byte(8'hDF, a); check(a, "R3 read addr ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(d[i], i == n - 1);
    hold(4);
    check(!sda_oe, "R8 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_reset();
    check(bright == 8'h3F, "R1 bright", bright, 8'h3F);
    check(offset == '0, "R1 offsets", offset[31:0], 0);
    check(!men, "R1 master_en", men, 0);
    check(chen == 8'h00, "R1 chan_en", chen, 0);
    check(!sda_oe, "R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_write_burst();
    bit a;
    set_ptr(8'h00, "wr");
    send_byte(8'hC1, a); check(a, "R6 data ack 0", a, 1);
    send_byte(8'h12, a); check(a, "R6 data ack 1", a, 1);
    send_byte(8'hA5, a); check(a, "R6 data ack 2", a, 1);
    bus_stop(); hold(Q);
    check(bright == 8'hC1, "R2 R5 bright msb first", bright, 8'hC1);
    check(offset[7:0] == 8'h12, "R5 ofs1", offset[7:0], 8'h12);
    check(offset[15:8] == 8'hA5, "R5 ofs2", offset[15:8], 8'hA5);
  endtask

  task automatic t_read_repeat();
    logic [7:0] d [4];
    read_at(8'h00, 3, d);
    check(d[0] == 8'hC1, "R7 read 0", d[0], 8'hC1);
    check(d[1] == 8'h12, "R7 read 1", d[1], 8'h12);
    check(d[2] == 8'hA5, "R7 read 2", d[2], 8'hA5);
  endtask

  task automatic t_wrong_addr();
    bit a;
    bus_start();
    send_byte(8'hA0, a); check(!a, "R4 no ack on other addr", a, 0);
    send_byte(8'h00, a); check(!a, "R4 no ack after miss", a, 0);
    send_byte(8'h77, a);
    bus_stop(); hold(Q);
    check(bright == 8'hC1, "R4 bright unchanged", bright, 8'hC1);
  endtask

  task automatic t_abort();
    set_ptr(8'h03, "abort");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop(); hold(Q);
    check(offset[23:16] == 8'h00, "R2 stop mid-byte drops", offset[23:16], 0);
  endtask

  task automatic t_sparse();
    bit a;
    logic [7:0] d [4];
    set_ptr(8'h2A, "sp");
    send_byte(8'hFF, a);
    send_byte(8'hC3, a);
    send_byte(8'h00, a); check(a, "R9 status write acked", a, 1);
    bus_stop(); hold(Q);
    check(men, "R11 master_en set", men, 1);
    check(chen == 8'hC3, "R10 chan_en", chen, 8'hC3);
    read_at(8'h2A, 3, d);
    check(d[0] == 8'h01, "R11 master_en reads bit0 only", d[0], 8'h01);
    check(d[1] == 8'hC3, "R10 chan_en read", d[1], 8'hC3);
    check(d[2] == 8'h5A, "R9 status read", d[2], 8'h5A);
    set_ptr(8'h08, "sp2");
    send_byte(8'h7E, a);
    send_byte(8'h99, a); check(a, "R10 gap write acked", a, 1);
    bus_stop(); hold(Q);
    check(offset[63:56] == 8'h7E, "R10 ofs8", offset[63:56], 8'h7E);
    read_at(8'h08, 2, d);
    check(d[0] == 8'h7E, "R10 ofs8 read", d[0], 8'h7E);
    check(d[1] == 8'h00, "R10 unmapped reads zero", d[1], 0);
    status = 8'hE7;
    read_at(8'h2C, 1, d);
    check(d[0] == 8'hE7, "R9 status follows input", d[0], 8'hE7);
  endtask

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(2);
    t_reset();
    t_write_burst();
    t_read_repeat();
    t_wrong_addr();
    t_abort();
    t_sparse();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule